// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block performs signed 32-bit multiplication and division over many clock cycles and keeps the outcome in a private pair of 32-bit result registers, called HI and LO. These registers are kept apart from the general register file. A requester offers an operation on a valid/ready request channel. The request carries an operation code and two operands. While the arithmetic runs, the unit raises a busy flag and deasserts ready. A separate read-select pin chooses which result register drives the read-data output. The move-from-HI and move-from-LO operations copy results out through this path.

The multiplier uses shift-and-add and the divider uses restoring division. Each retires one operand bit per cycle on the magnitudes of the operands, and the signs are fixed up as the results are written.

Back-pressure rules on the request channel:
- The unit accepts a request on a rising edge where `req_valid` and `req_ready` are both high.
- `req_ready` is low for the whole of an operation.
- The unit does not capture a request that is presented while it is busy. That request has no effect. A requester that still wants it must keep `req_valid` high until `req_ready` returns.

Top module: `hilo_muldiv`

## Requirements
- R1: After reset, `busy` is 0, `req_ready` is 1, and both HI and LO read as zero.
- R2: A request is accepted on an edge where `req_valid` and `req_ready` are both 1. `busy` is 1 and `req_ready` is 0 from the following cycle.
- R3: After an accepted request, `busy` stays 1 for exactly 32 cycles. HI and LO take their new values on the same edge where `busy` falls.
- R4: While `busy` is 1, `req_valid` with any operands has no effect: the operation does not restart, and its results are those of the accepted operands.
- R5: `req_op` = 0 selects multiply. The operands are signed two's complement, HI receives product bits 63..32 and LO receives product bits 31..0.
- R6: `req_op` = 1 selects divide, with `req_a` as dividend and `req_b` as divisor. LO receives the signed quotient truncated toward zero, keeping its low 32 bits (so -2^31 / -1 gives 0x80000000).
- R7: For a divide, HI receives the remainder. The remainder carries the sign of the dividend and satisfies dividend = quotient*divisor + remainder.
- R8: A divide by zero completes in the normal time and leaves LO = 0xFFFFFFFF and HI = the dividend.
- R9: `rd_data` shows HI when `rd_sel_hi` = 1 and LO when `rd_sel_hi` = 0, in the same cycle.
- R10: HI and LO hold their values at all times other than the completion edge of an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can accept a request (not busy) |
| req_op | input | 1 | 0 = multiply, 1 = divide |
| req_a | input | 32 | Multiplicand or dividend, signed |
| req_b | input | 32 | Multiplier or divisor, signed |
| busy | output | 1 | Operation in progress |
| rd_sel_hi | input | 1 | 1 selects HI, 0 selects LO |
| rd_data | output | 32 | Selected result register |

## Verification
The `busy` flag is due one cycle after the acceptance edge. The new HI and LO values are due exactly 32 edges after acceptance, on the edge where `busy` falls, and `rd_data` follows the read select with no delay.

The bench drives inputs on falling edges and counts rising edges from acceptance. After 31 edges it checks that `busy` is still high and the old results are unchanged. After the 32nd edge it checks that `busy` has dropped and both registers match the values computed in the bench. Requests offered during an operation are checked by confirming that the schedule and the results are those of the first operands.

// File: rtl/hilo_pkg.sv
package hilo_pkg;
  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } hilo_op_e;

  function automatic logic [31:0] mag32(input logic [31:0] v);
    return v[31] ? (~v + 32'd1) : v;
  endfunction
endpackage

// File: rtl/hilo_seq.sv
module hilo_seq #(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic last
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (busy) begin
      if (cnt_q == LAST_CNT) busy <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last = busy && (cnt_q == LAST_CNT);

  p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  p_busy_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy);
  p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy);
  p_no_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/hilo_mul_core.sv
module hilo_mul_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] prod_nxt
);
  logic [W-1:0] mcand_q, upper_q, lower_q;
  logic [W:0]   sum;

  always_comb begin
    sum      = {1'b0, upper_q} + (lower_q[0] ? {1'b0, mcand_q} : '0);
    prod_nxt = {sum, lower_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      upper_q <= '0;
      lower_q <= '0;
    end else if (load) begin
      mcand_q <= mcand;
      upper_q <= '0;
      lower_q <= mplier;
    end else if (step) begin
      upper_q <= prod_nxt[2*W-1:W];
      lower_q <= prod_nxt[W-1:0];
    end
  end
endmodule

// File: rtl/hilo_div_core.sv
module hilo_div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo_nxt,
  output logic [W-1:0] rem_nxt
);
  logic [W-1:0] dvs_q, rem_q, quo_q;
  logic [W:0]   shifted;
  logic [W+1:0] trial;
  logic         fits;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = {1'b0, shifted} - {2'b00, dvs_q};
    fits    = !trial[W+1];
    rem_nxt = fits ? trial[W-1:0] : shifted[W-1:0];
    quo_nxt = {quo_q[W-2:0], fits};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvs_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
    end else if (load) begin
      dvs_q <= divisor;
      rem_q <= '0;
      quo_q <= dividend;
    end else if (step) begin
      rem_q <= rem_nxt;
      quo_q <= quo_nxt;
    end
  end

  p_rem_below_divisor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && dvs_q != '0) |=> (rem_q < dvs_q));
endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv
  import hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic         req_op,
  input  logic [W-1:0] req_a,
  input  logic [W-1:0] req_b,
  output logic         busy,
  input  logic         rd_sel_hi,
  output logic [W-1:0] rd_data
);
  localparam int PW = 2 * W;

  logic           start, last;
  logic [W-1:0]   mag_a, mag_b;
  logic [PW-1:0]  prod_nxt, prod_signed;
  logic [W-1:0]   quo_nxt, rem_nxt, quo_signed, rem_signed;
  logic [W-1:0]   hi_q, lo_q, dvd_q;
  hilo_op_e       op_q;
  logic           neg_q, sa_q, dz_q;

  assign req_ready = !busy;
  assign start     = req_valid && !busy;
  assign mag_a     = req_a[W-1] ? (~req_a + 1'b1) : req_a;
  assign mag_b     = req_b[W-1] ? (~req_b + 1'b1) : req_b;

  hilo_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .last(last)
  );

  hilo_mul_core #(.W(W)) u_mul (
    .clk(clk), .rst_n(rst_n),
    .load(start && req_op == OP_MUL), .step(busy && op_q == OP_MUL),
    .mcand(mag_a), .mplier(mag_b), .prod_nxt(prod_nxt)
  );

  hilo_div_core #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n),
    .load(start && req_op == OP_DIV), .step(busy && op_q == OP_DIV),
    .dividend(mag_a), .divisor(mag_b), .quo_nxt(quo_nxt), .rem_nxt(rem_nxt)
  );

  always_comb begin
    prod_signed = neg_q ? (~prod_nxt + 1'b1) : prod_nxt;
    quo_signed  = neg_q ? (~quo_nxt + 1'b1) : quo_nxt;
    rem_signed  = sa_q ? (~rem_nxt + 1'b1) : rem_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_MUL;
      neg_q <= 1'b0;
      sa_q  <= 1'b0;
      dz_q  <= 1'b0;
      dvd_q <= '0;
    end else if (start) begin
      op_q  <= hilo_op_e'(req_op);
      neg_q <= req_a[W-1] ^ req_b[W-1];
      sa_q  <= req_a[W-1];
      dz_q  <= (req_b == '0);
      dvd_q <= req_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (last) begin
      if (op_q == OP_MUL) begin
        hi_q <= prod_signed[PW-1:W];
        lo_q <= prod_signed[W-1:0];
      end else if (dz_q) begin
        hi_q <= dvd_q;
        lo_q <= '1;
      end else begin
        hi_q <= rem_signed;
        lo_q <= quo_signed;
      end
    end
  end

  assign rd_data = rd_sel_hi ? hi_q : lo_q;

  p_hold_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> ($stable(hi_q) && $stable(lo_q)));
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(hi_q) && $stable(lo_q)));
  p_divzero_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (last && op_q == OP_DIV && dz_q) |=> (lo_q == '1 && hi_q == $past(dvd_q)));
  p_rem_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (last && op_q == OP_DIV && !dz_q) |=> (hi_q == '0 || hi_q[W-1] == $past(sa_q)));
endmodule

// File: tb/tb_hilo_muldiv.sv
`timescale 1ns/1ps
module tb_hilo_muldiv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_op = 1'b0;
  logic [31:0] req_a = '0;
  logic [31:0] req_b = '0;
  logic        busy;
  logic        rd_sel_hi = 1'b0;
  logic [31:0] rd_data;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hilo_muldiv dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_a(req_a), .req_b(req_b), .busy(busy),
    .rd_sel_hi(rd_sel_hi), .rd_data(rd_data)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_result(bit op, logic [31:0] a, logic [31:0] b);
    longint sa, sb, p, q, r;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    if (!op) begin
      p = sa * sb;
      return p;
    end
    if (b == 0) return {a, 32'hFFFF_FFFF};
    q = sa / sb;
    r = sa % sb;
    return {r[31:0], q[31:0]};
  endfunction

  task automatic read_regs(output logic [31:0] hi, output logic [31:0] lo);
    rd_sel_hi = 1'b1; #0.5; hi = rd_data;
    rd_sel_hi = 1'b0; #0.5; lo = rd_data;
  endtask

  task automatic run_op(bit op, logic [31:0] a, logic [31:0] b, bit noisy, string tag);
    logic [63:0] exp;
    logic [31:0] hi, lo, old_hi, old_lo;
    exp = exp_result(op, a, b);
    read_regs(old_hi, old_lo);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_a = a; req_b = b;
    @(posedge clk);
    for (int i = 1; i <= 31; i++) begin
      @(negedge clk);
      if (i == 1) begin
        check("R2 busy after accept", {31'b0, busy}, 32'd1);
        check("R2 ready low while busy", {31'b0, req_ready}, 32'd0);
      end
      if (noisy && i <= 5) begin
        req_valid = 1'b1; req_op = ~op; req_a = $urandom; req_b = $urandom;
      end else begin
        req_valid = 1'b0;
      end
    end
    @(negedge clk);
    check(noisy ? "R4 busy at edge 31" : "R3 busy at edge 31", {31'b0, busy}, 32'd1);
    read_regs(hi, lo);
    check("R10 HI held while busy", hi, old_hi);
    check("R10 LO held while busy", lo, old_lo);
    @(negedge clk);
    check("R3 busy fell at edge 32", {31'b0, busy}, 32'd0);
    read_regs(hi, lo);
    check({tag, " HI"}, hi, exp[63:32]);
    check({tag, " LO"}, lo, exp[31:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] hi, lo, h2, l2;
    void'($urandom(32'd1234));
    #1;
    read_regs(hi, lo);
    check("R1 busy in reset", {31'b0, busy}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", {31'b0, busy}, 32'd0);
    check("R1 ready after reset", {31'b0, req_ready}, 32'd1);
    read_regs(hi, lo);
    check("R1 HI zero", hi, 32'd0);
    check("R1 LO zero", lo, 32'd0);

    run_op(1'b0, 32'd7, 32'd6, 0, "R5 mul small");
    run_op(1'b0, 32'hFFFF_FFFF, 32'd5, 0, "R5 mul neg");
    run_op(1'b0, 32'h8000_0000, 32'h8000_0000, 0, "R5 mul min*min");
    run_op(1'b0, 32'h7FFF_FFFF, 32'h8000_0000, 0, "R5 mul max*min");
    run_op(1'b1, 32'd100, 32'd7, 0, "R6 R7 div pos");
    run_op(1'b1, 32'hFFFF_FF9C, 32'd7, 0, "R6 R7 div neg dividend");
    run_op(1'b1, 32'd100, 32'hFFFF_FFF9, 0, "R6 R7 div neg divisor");
    run_op(1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 0, "R6 div min by -1");
    run_op(1'b1, 32'd3, 32'd10, 0, "R6 R7 div small");
    run_op(1'b1, 32'hDEAD_BEEF, 32'd0, 0, "R8 div by zero");
    run_op(1'b1, 32'd0, 32'd0, 0, "R8 zero by zero");
    run_op(1'b0, 32'd12345, 32'hFFFF_0000, 1, "R4 mul with requests while busy");
    run_op(1'b1, 32'h1234_5678, 32'h0000_0099, 1, "R4 div with requests while busy");

    read_regs(hi, lo);
    repeat (5) @(negedge clk);
    read_regs(h2, l2);
    check("R10 HI held idle", h2, hi);
    check("R10 LO held idle", l2, lo);
    rd_sel_hi = 1'b1; #0.5;
    check("R9 select HI", rd_data, hi);
    rd_sel_hi = 1'b0; #0.5;
    check("R9 select LO", rd_data, lo);

    for (int n = 0; n < 40; n++) begin
      logic [31:0] a, b;
      bit op;
      a = $urandom; b = $urandom; op = $urandom_range(0, 1);
      if (n % 8 == 3) b = b & 32'h0000_00FF;
      if (n % 8 == 5) a = a >>> ($urandom_range(0, 31));
      run_op(op, a, b, (n % 5 == 0), op ? "R6 R7 random div" : "R5 random mul");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule